// File: doc/BRIEF.md
# Serial EEPROM Host Command Controller

This block is the host-side master for a three-wire serial EEPROM that holds 64 words of 16 bits. A local requester hands it one command at a time through a valid/ready request port: an operation code, a word address and, for the programming commands, a data word. The controller turns the command into a serial frame and drives it onto chip select, serial clock and serial data out. When the frame is a read, it gathers the returned word from serial data in.

Frames come in two lengths. Short commands send 9 clock periods. Commands that carry a data word, in either direction, send 25. The serial clock comes from a programmable divider of the system clock. After any command that programs the array, the controller drops chip select and waits a minimum deselect time. It then raises chip select again and watches serial data in until the device reports ready. A poll limit stops a device that never reports ready and flags an error. A one-cycle done strobe marks the end of every operation. Chip select is always held low for at least the deselect time before the next frame.

Top module: `eeprom_host`

## Requirements
- R1: Every frame starts with a 1 bit, then a 2-bit device opcode, then the 6-bit address, all MSB first. The device opcode is 10 for read (`req_op`=0), 01 for write (`req_op`=1) and 11 for erase (`req_op`=2). These three carry `req_addr` in the address field.
- R2: The remaining request codes send device opcode 00. The top two address bits then pick the action: enable programming (`req_op`=3) sends 11, erase all (`req_op`=5) sends 10, write all (`req_op`=6) sends 01, and disable programming (`req_op`=4, and the unused code 7) sends 00. The low four address bits are sent as 0.
- R3: Each chip-select window gives exactly 25 rising serial clock edges for read, write and write all, exactly 9 for the other commands, and none for a ready poll.
- R4: `sdo` changes only while `sclk` is low, so it is stable at every rising edge.
- R5: On a read, `sdi` is ignored during the 9 command bits. The bit present after rising edge n (n = 10..25) is captured, and `rd_data` holds those 16 bits, with the bit after edge 10 as bit 15, when done pulses.
- R6: Write and write all send `req_wdata` MSB first as bits 10..25 of the frame. All other commands send no data bits.
- R7: Chip select stays low for at least `T_CSL` system clock cycles every time it falls.
- R8: After write, erase, erase all and write all, chip select goes low for the deselect time, then high with no serial clock. It then goes low again as soon as `sdi` reads 1, and done follows.
- R9: If `sdi` has not read 1 after `POLL_LIMIT` polling cycles, polling ends and `timeout_err` is 1 when done pulses. The next accepted request clears it.
- R10: A request is taken only while `req_ready` is 1, which holds only while the block is idle. `req_valid` at any other time has no effect.
- R11: `done` is a pulse of exactly one system clock cycle per accepted request.
- R12: Out of reset: `cs`, `sclk`, `sdo`, `done`, `timeout_err` are 0, `rd_data` is 0, and `req_ready` is 1.
- R13: Each serial clock half period lasts `DIV_HALF` system clock cycles, and `sclk` is low whenever `cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Request code (see R1, R2) |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Data for write and write all |
| req_ready | output | 1 | Controller idle, request will be taken |
| done | output | 1 | One-cycle end-of-operation strobe |
| rd_data | output | 16 | Word returned by the last read |
| timeout_err | output | 1 | Ready never seen during the last poll |
| cs | output | 1 | Device chip select, active high |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the device |
| sdi | input | 1 | Serial data and ready/busy from the device |

## Verification
A stuck or misrouted control state shows up at the pins within one frame. A bit index that is off by one gives a chip-select window with 8, 10, 24 or 26 clock edges, and the edge count is checked when chip select falls. A wrong shift or opcode table corrupts the header that the device model reads back. A capture window that is shifted skews `rd_data`, and a polling state that is wrong shows up as a missing or extra clockless chip-select window, or as a deselect gap shorter than `T_CSL`. These faults are visible by the next done strobe, which is at most a few hundred cycles later.

// File: rtl/eeprom_host_pkg.sv
package eeprom_host_pkg;

  // Request codes on req_op
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_PGMEN = 3'd3,
    OP_PGMDS = 3'd4,
    OP_CLRALL = 3'd5,
    OP_FILLALL = 3'd6,
    OP_SPARE = 3'd7
  } host_op_e;

  // Controller states
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_LO   = 3'd1,
    S_HI   = 3'd2,
    S_TAIL = 3'd3,
    S_GAP  = 3'd4,
    S_POLL = 3'd5
  } ctl_state_e;

  // Device opcode field values
  localparam logic [1:0] DEVOP_READ = 2'b10;
  localparam logic [1:0] DEVOP_WRITE = 2'b01;
  localparam logic [1:0] DEVOP_ERASE = 2'b11;
  localparam logic [1:0] DEVOP_SPECIAL = 2'b00;

  // Selector in the top address bits for opcode 00
  localparam logic [1:0] SEL_PGMEN = 2'b11;
  localparam logic [1:0] SEL_PGMDS = 2'b00;
  localparam logic [1:0] SEL_CLRALL = 2'b10;
  localparam logic [1:0] SEL_FILLALL = 2'b01;

endpackage

// File: rtl/eeprom_host_frame.sv
module eeprom_host_frame
  import eeprom_host_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int CMD_BITS = 3 + AW,
  localparam int FRAME_W = CMD_BITS + DW,
  localparam int LEN_W = $clog2(FRAME_W + 1)
) (
  input  logic [2:0]         op,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [FRAME_W-1:0] word,
  output logic [LEN_W-1:0]   nbits,
  output logic               is_read,
  output logic               needs_poll
);

  host_op_e      op_e;
  logic [1:0]    devop;
  logic [AW-1:0] fld;
  logic          carries_data;

  assign op_e = host_op_e'(op);

  always_comb begin
    devop        = DEVOP_SPECIAL;
    fld          = {SEL_PGMDS, {(AW-2){1'b0}}};
    carries_data = 1'b0;
    is_read      = 1'b0;
    needs_poll   = 1'b0;
    case (op_e)
      OP_READ: begin
        devop        = DEVOP_READ;
        fld          = addr;
        carries_data = 1'b1;
        is_read      = 1'b1;
      end
      OP_WRITE: begin
        devop        = DEVOP_WRITE;
        fld          = addr;
        carries_data = 1'b1;
        needs_poll   = 1'b1;
      end
      OP_ERASE: begin
        devop      = DEVOP_ERASE;
        fld        = addr;
        needs_poll = 1'b1;
      end
      OP_PGMEN: fld = {SEL_PGMEN, {(AW-2){1'b0}}};
      OP_CLRALL: begin
        fld        = {SEL_CLRALL, {(AW-2){1'b0}}};
        needs_poll = 1'b1;
      end
      OP_FILLALL: begin
        fld          = {SEL_FILLALL, {(AW-2){1'b0}}};
        carries_data = 1'b1;
        needs_poll   = 1'b1;
      end
      default: fld = {SEL_PGMDS, {(AW-2){1'b0}}};
    endcase
  end

  always_comb begin
    word  = {1'b1, devop, fld, (carries_data && !is_read) ? wdata : {DW{1'b0}}};
    nbits = carries_data ? LEN_W'(FRAME_W) : LEN_W'(CMD_BITS);
  end

endmodule

// File: rtl/eeprom_host_cnt.sv
module eeprom_host_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr)      q_nxt = '0;
    else if (inc) q_nxt = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/eeprom_host.sv
module eeprom_host
  import eeprom_host_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int T_CSL = 5,
  parameter int POLL_LIMIT = 200,
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          timeout_err,
  output logic          cs,
  output logic          sclk,
  output logic          sdo,
  input  logic          sdi
);

  localparam int CMD_BITS = 3 + AW;
  localparam int FRAME_W = CMD_BITS + DW;
  localparam int LEN_W = $clog2(FRAME_W + 1);
  localparam int HC_W = $clog2(DIV_HALF + 1);
  localparam int GC_W = $clog2(T_CSL + 1);
  localparam int PC_W = $clog2(POLL_LIMIT + 1);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Frame builder
  logic [FRAME_W-1:0] f_word;
  logic [LEN_W-1:0]   f_len;
  logic               f_rd;
  logic               f_poll;

  eeprom_host_frame #(.AW(AW), .DW(DW)) u_frame (
    .op         (req_op),
    .addr       (req_addr),
    .wdata      (req_wdata),
    .word       (f_word),
    .nbits      (f_len),
    .is_read    (f_rd),
    .needs_poll (f_poll)
  );

  // State
  ctl_state_e         state, state_nxt;
  logic [FRAME_W-1:0] shreg, shreg_nxt;
  logic [LEN_W-1:0]   idx, idx_nxt;
  logic [LEN_W-1:0]   nbits, nbits_nxt;
  logic               rd_op, rd_op_nxt;
  logic               pgm_op, pgm_op_nxt;
  logic               polled, polled_nxt;
  logic [DW-1:0]      rd_shift, rd_shift_nxt;
  logic [DW-1:0]      rd_data_nxt;
  logic               done_nxt, err_nxt;
  logic               cs_nxt, sclk_nxt, sdo_nxt;

  // Timers
  logic [HC_W-1:0] hq;
  logic [GC_W-1:0] gq;
  logic [PC_W-1:0] pq;
  logic            in_bits;
  logic            half_done;
  logic            gap_done;
  logic            poll_expired;

  assign in_bits = (state == S_LO) || (state == S_HI) || (state == S_TAIL);

  eeprom_host_cnt #(.W(HC_W)) u_half (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (half_done || !in_bits),
    .inc   (in_bits),
    .q     (hq)
  );

  eeprom_host_cnt #(.W(GC_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (state != S_GAP),
    .inc   (state == S_GAP),
    .q     (gq)
  );

  eeprom_host_cnt #(.W(PC_W)) u_poll (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (state != S_POLL),
    .inc   (state == S_POLL),
    .q     (pq)
  );

  assign half_done    = in_bits && (hq == HC_W'(DIV_HALF - 1));
  assign gap_done     = (state == S_GAP) && (gq == GC_W'(T_CSL - 1));
  assign poll_expired = (pq == PC_W'(POLL_LIMIT - 1));
  assign req_ready    = (state == S_IDLE);

  // Next-state logic
  always_comb begin
    state_nxt    = state;
    shreg_nxt    = shreg;
    idx_nxt      = idx;
    nbits_nxt    = nbits;
    rd_op_nxt    = rd_op;
    pgm_op_nxt   = pgm_op;
    polled_nxt   = polled;
    rd_shift_nxt = rd_shift;
    rd_data_nxt  = rd_data;
    done_nxt     = 1'b0;
    err_nxt      = timeout_err;
    cs_nxt       = cs;
    sclk_nxt     = sclk;
    sdo_nxt      = sdo;

    case (state)
      S_IDLE: begin
        if (req_valid) begin
          shreg_nxt  = f_word;
          nbits_nxt  = f_len;
          rd_op_nxt  = f_rd;
          pgm_op_nxt = f_poll;
          polled_nxt = 1'b0;
          err_nxt    = 1'b0;
          idx_nxt    = '0;
          cs_nxt     = 1'b1;
          sclk_nxt   = 1'b0;
          sdo_nxt    = f_word[FRAME_W-1];
          state_nxt  = S_LO;
        end
      end
      S_LO: begin
        if (half_done) begin
          sclk_nxt  = 1'b1;
          state_nxt = S_HI;
        end
      end
      S_HI: begin
        if (half_done) begin
          sclk_nxt = 1'b0;
          if (rd_op && (idx >= LEN_W'(CMD_BITS)))
            rd_shift_nxt = {rd_shift[DW-2:0], sdi};
          if (idx == nbits - 1'b1) begin
            sdo_nxt   = 1'b0;
            state_nxt = S_TAIL;
            if (rd_op) rd_data_nxt = {rd_shift[DW-2:0], sdi};
          end else begin
            idx_nxt   = idx + 1'b1;
            shreg_nxt = shreg << 1;
            sdo_nxt   = shreg[FRAME_W-2];
            state_nxt = S_LO;
          end
        end
      end
      S_TAIL: begin
        if (half_done) begin
          cs_nxt    = 1'b0;
          state_nxt = S_GAP;
        end
      end
      S_GAP: begin
        if (gap_done) begin
          if (pgm_op && !polled) begin
            cs_nxt    = 1'b1;
            state_nxt = S_POLL;
          end else begin
            done_nxt  = 1'b1;
            state_nxt = S_IDLE;
          end
        end
      end
      S_POLL: begin
        if (sdi) begin
          cs_nxt     = 1'b0;
          polled_nxt = 1'b1;
          state_nxt  = S_GAP;
        end else if (poll_expired) begin
          cs_nxt     = 1'b0;
          polled_nxt = 1'b1;
          err_nxt    = 1'b1;
          state_nxt  = S_GAP;
        end
      end
      default: state_nxt = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state       <= S_IDLE;
      shreg       <= '0;
      idx         <= '0;
      nbits       <= '0;
      rd_op       <= 1'b0;
      pgm_op      <= 1'b0;
      polled      <= 1'b0;
      rd_shift    <= '0;
      rd_data     <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      cs          <= 1'b0;
      sclk        <= 1'b0;
      sdo         <= 1'b0;
    end else begin
      state       <= state_nxt;
      shreg       <= shreg_nxt;
      idx         <= idx_nxt;
      nbits       <= nbits_nxt;
      rd_op       <= rd_op_nxt;
      pgm_op      <= pgm_op_nxt;
      polled      <= polled_nxt;
      rd_shift    <= rd_shift_nxt;
      rd_data     <= rd_data_nxt;
      done        <= done_nxt;
      timeout_err <= err_nxt;
      cs          <= cs_nxt;
      sclk        <= sclk_nxt;
      sdo         <= sdo_nxt;
    end
  end

endmodule

// File: rtl/eeprom_host_chk.sv
module eeprom_host_chk #(
  parameter int T_CSL = 5,
  parameter int CMD_BITS = 9,
  parameter int FRAME_W = 25,
  localparam int LC_W = $clog2(T_CSL + 1),
  localparam int EW = $clog2(FRAME_W + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sclk,
  input logic sdo,
  input logic done,
  input logic req_ready
);

  logic [LC_W-1:0] low_cnt;
  logic [EW-1:0]   edges;
  logic            sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= LC_W'(T_CSL);
      edges   <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (cs)                         low_cnt <= '0;
      else if (low_cnt < LC_W'(T_CSL)) low_cnt <= low_cnt + 1'b1;
      if (!cs)                   edges <= '0;
      else if (sclk && !sclk_d)  edges <= edges + 1'b1;
    end
  end

  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs) |-> (edges == '0 || edges == EW'(CMD_BITS) || edges == EW'(FRAME_W))); // R3

  AST_SDO_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdo)); // R4

  AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs) |-> (low_cnt >= LC_W'(T_CSL))); // R7

  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cs); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !sclk); // R13

endmodule

bind eeprom_host eeprom_host_chk #(
  .T_CSL    (T_CSL),
  .CMD_BITS (CMD_BITS),
  .FRAME_W  (FRAME_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .sclk      (sclk),
  .sdo       (sdo),
  .done      (done),
  .req_ready (req_ready)
);

// File: tb/eeprom_host_bench.sv
module eeprom_host_bench;

  localparam int CLK_P = 10;
  localparam int DIV_HALF = 2;
  localparam int T_CSL = 5;
  localparam int POLL_LIMIT = 200;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [5:0]  req_addr;
  logic [15:0] req_wdata;
  logic        req_ready;
  logic        done;
  logic [15:0] rd_data;
  logic        timeout_err;
  logic        cs;
  logic        sclk;
  logic        sdo;
  logic        sdi;

  eeprom_host #(
    .DIV_HALF   (DIV_HALF),
    .T_CSL      (T_CSL),
    .POLL_LIMIT (POLL_LIMIT),
    .AW         (6),
    .DW         (16)
  ) u_eeprom_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .done        (done),
    .rd_data     (rd_data),
    .timeout_err (timeout_err),
    .cs          (cs),
    .sclk        (sclk),
    .sdo         (sdo),
    .sdi         (sdi)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // ---------------- Device model (observes at negedge) ----------------
  int          busy_len;
  logic [15:0] dev_word;
  int          busy_cnt;
  int          ecount;
  logic [24:0] shcap;
  logic [8:0]  hdr;
  logic        rd_phase;
  logic        dout;
  logic        prev_cs, prev_sclk, prev_sdo;
  int          n_frames, n_polls;
  int          last_len;
  logic [24:0] last_bits;
  int          viol_sdo, viol_sclk;
  int          hi_run, hi_min, hi_max;
  int          low_run, min_gap;

  function automatic logic [8:0] head_of(input int len, input logic [24:0] bits);
    return (len == 9) ? bits[8:0] : bits[24:16];
  endfunction

  function automatic bit is_pgm(input logic [8:0] h);
    return (h[7:6] == 2'b01) || (h[7:6] == 2'b11) ||
           (h[7:6] == 2'b00 && (h[5:4] == 2'b10 || h[5:4] == 2'b01));
  endfunction

  assign sdi = !cs ? 1'b0 : (rd_phase ? dout : (busy_cnt == 0));

  initial begin
    busy_cnt = 0; ecount = 0; shcap = '0; hdr = '0; rd_phase = 1'b0; dout = 1'b0;
    prev_cs = 1'b0; prev_sclk = 1'b0; prev_sdo = 1'b0;
    n_frames = 0; n_polls = 0; last_len = 0; last_bits = '0;
    viol_sdo = 0; viol_sclk = 0; hi_run = 0; hi_min = 1000; hi_max = 0;
    low_run = 0; min_gap = 1000;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (cs && sclk && !prev_sclk) begin
        if (sdo != prev_sdo) viol_sdo <= viol_sdo + 1;
        shcap  <= {shcap[23:0], sdo};
        ecount <= ecount + 1;
        if (ecount == 8) hdr <= {shcap[7:0], sdo};
        if (ecount >= 9 && hdr[7:6] == 2'b10) begin
          rd_phase <= 1'b1;
          dout     <= dev_word[24-ecount];
        end
      end
      if (cs && sclk && prev_sclk && sdo != prev_sdo) viol_sdo <= viol_sdo + 1;
      if (!cs && sclk) viol_sclk <= viol_sclk + 1;
      if (sclk) hi_run <= hi_run + 1;
      else if (prev_sclk) begin
        if (hi_run < hi_min) hi_min <= hi_run;
        if (hi_run > hi_max) hi_max <= hi_run;
        hi_run <= 0;
      end
      if (!cs) low_run <= low_run + 1;
      if (cs && !prev_cs) begin
        if (low_run < min_gap) min_gap <= low_run;
        low_run <= 0;
      end
      if (!cs && prev_cs) begin
        if (ecount == 0) n_polls <= n_polls + 1;
        else begin
          n_frames  <= n_frames + 1;
          last_len  <= ecount;
          last_bits <= shcap;
          if (is_pgm(head_of(ecount, shcap))) busy_cnt <= busy_len;
        end
        ecount   <= 0;
        rd_phase <= 1'b0;
      end
      prev_cs   <= cs;
      prev_sclk <= sclk;
      prev_sdo  <= sdo;
    end
  end

  // ---------------- Checking ----------------
  int errors;
  int checks;
  bit finished;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [5:0] a, input logic [15:0] wd);
    int n;
    n = 0;
    @(negedge clk);
    while (!req_ready && n < 20000) begin @(negedge clk); n++; end
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    int n;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    seen = done;
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [5:0]  addr;
    logic [15:0] wd;
    logic [8:0]  hdr;
    logic [4:0]  len;
    logic [1:0]  polls;
    logic [10:0] busy;
    logic [15:0] dev;
    logic [15:0] rd;
    logic        err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'd3, 6'h15, 16'h0000, 9'b1_00_11_0000, 5'd9,  2'd0, 11'd0,    16'h0000, 16'h0000, 1'b0},
    '{3'd1, 6'h2A, 16'hA5C3, 9'b1_01_101010,  5'd25, 2'd1, 11'd40,   16'h0000, 16'h0000, 1'b0},
    '{3'd0, 6'h2A, 16'h0000, 9'b1_10_101010,  5'd25, 2'd0, 11'd0,    16'hBEEF, 16'hBEEF, 1'b0},
    '{3'd0, 6'h01, 16'h0000, 9'b1_10_000001,  5'd25, 2'd0, 11'd0,    16'h0000, 16'h0000, 1'b0},
    '{3'd0, 6'h3F, 16'h0000, 9'b1_10_111111,  5'd25, 2'd0, 11'd0,    16'hFFFF, 16'hFFFF, 1'b0},
    '{3'd2, 6'h05, 16'h0000, 9'b1_11_000101,  5'd9,  2'd1, 11'd10,   16'h0000, 16'h0000, 1'b0},
    '{3'd5, 6'h2A, 16'h0000, 9'b1_00_10_0000, 5'd9,  2'd1, 11'd0,    16'h0000, 16'h0000, 1'b0},
    '{3'd6, 6'h3F, 16'h1234, 9'b1_00_01_0000, 5'd25, 2'd1, 11'd25,   16'h0000, 16'h0000, 1'b0},
    '{3'd4, 6'h3F, 16'h0000, 9'b1_00_00_0000, 5'd9,  2'd0, 11'd0,    16'h0000, 16'h0000, 1'b0},
    '{3'd1, 6'h10, 16'h8001, 9'b1_01_010000,  5'd25, 2'd1, 11'd1000, 16'h0000, 16'h0000, 1'b1},
    '{3'd0, 6'h22, 16'h0000, 9'b1_10_100010,  5'd25, 2'd0, 11'd0,    16'h6C93, 16'h6C93, 1'b0}
  };

  initial begin
    errors = 0; checks = 0; finished = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    busy_len = 0; dev_word = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(cs == 1'b0 && sclk == 1'b0 && sdo == 1'b0, "R12 serial pins in reset", {29'd0, cs, sclk, sdo}, 32'd0);
    chk(done == 1'b0 && timeout_err == 1'b0, "R12 done/err in reset", {30'd0, done, timeout_err}, 32'd0);
    chk(rd_data == 16'h0000, "R12 rd_data in reset", rd_data, 32'd0);
    chk(req_ready == 1'b1, "R12 ready in reset", req_ready, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int  f0, p0;
      bit  seen;
      logic [8:0] h;
      busy_len = VEC[i].busy;
      dev_word = VEC[i].dev;
      f0 = n_frames; p0 = n_polls;
      issue(VEC[i].op, VEC[i].addr, VEC[i].wd);
      wait_done(seen);
      chk(seen, "R11 done strobe seen", seen, 32'd1);
      chk(n_frames == f0 + 1, "R3 one frame per request", n_frames - f0, 32'd1);
      chk(last_len == int'(VEC[i].len), "R3 clock edges in frame", last_len, VEC[i].len);
      h = head_of(last_len, last_bits);
      chk(h == VEC[i].hdr, (VEC[i].op > 3'd2) ? "R2 special header" : "R1 header", h, VEC[i].hdr);
      if (VEC[i].len == 5'd25 && VEC[i].op != 3'd0)
        chk(last_bits[15:0] == VEC[i].wd, "R6 data bits", last_bits[15:0], VEC[i].wd);
      if (VEC[i].op == 3'd0)
        chk(rd_data == VEC[i].rd, "R5 read word", rd_data, VEC[i].rd);
      chk(n_polls - p0 == int'(VEC[i].polls), "R8 ready poll windows", n_polls - p0, VEC[i].polls);
      chk(timeout_err == VEC[i].err, "R9 timeout flag", timeout_err, VEC[i].err);
      @(negedge clk);
      chk(done == 1'b0, "R11 done lasts one cycle", done, 32'd0);
    end

    // R10: request while busy is ignored
    begin
      int  f0;
      bit  seen;
      busy_len = 0; dev_word = 16'h5A5A;
      f0 = n_frames;
      issue(3'd0, 6'h03, 16'h0000);
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_op = 3'd6; req_addr = 6'h00; req_wdata = 16'hFFFF;
      repeat (10) @(negedge clk);
      req_valid = 1'b0;
      wait_done(seen);
      chk(seen, "R10 done after busy request", seen, 32'd1);
      chk(head_of(last_len, last_bits) == 9'b1_10_000011, "R10 frame kept", head_of(last_len, last_bits), 9'b1_10_000011);
      chk(rd_data == 16'h5A5A, "R10 read unaffected", rd_data, 16'h5A5A);
      repeat (200) @(negedge clk);
      chk(n_frames == f0 + 1, "R10 no extra frame", n_frames - f0, 32'd1);
      chk(req_ready == 1'b1 && cs == 1'b0, "R10 idle after", {30'd0, req_ready, cs}, 32'd2);
    end

    // Whole-run timing observations
    chk(viol_sdo == 0, "R4 sdo changes while sclk high", viol_sdo, 32'd0);
    chk(min_gap >= T_CSL, "R7 minimum deselect", min_gap, T_CSL);
    chk(hi_min == DIV_HALF && hi_max == DIV_HALF, "R13 high half period", hi_max, DIV_HALF);
    chk(viol_sclk == 0, "R13 sclk without cs", viol_sclk, 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule